// File: doc/BRIEF.md
# Dual-Priority Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a byte stream. Software lays out a circular list of transmit descriptors in memory for each of two queues, a high-priority one and a low-priority one. It programs each queue's ring start address through the register port and then writes a command word to launch one or both queues. For each launched queue the engine walks the ring from its start address. It streams out every frame that hardware owns, hands each such descriptor back to software by clearing its ownership flag, and raises a per-queue interrupt cause.

The engine reaches memory through a simple word-wide master that keeps one request outstanding and waits for `mem_ready`. Frames leave on a byte stream with valid, start and end markers, one byte per beat. The interrupt line is the OR of the enabled cause bits.

Top module: `txr_engine`

## Requirements
- R1: After reset `busy`, `irq`, `mem_req` and `tx_valid` are low, and the pointer, cause and mask registers read as zero.
- R2: The ring start address of the low queue (queue 0) is written and read at offset 0x4E0, and that of the high queue (queue 1) at offset 0x4E4.
- R3: A descriptor is four consecutive little-endian 32-bit words read in address order. Word 0 holds status with the ownership flag in bit 31. Word 1 holds the byte count in bits 31:16. Word 2 holds the word-aligned buffer address. Word 3 holds the address of the next descriptor.
- R4: A walk starts at the queue's start address, follows the next links, and stops after the descriptor whose next address equals the start address. A descriptor whose bit 31 is clear is skipped: it produces no bytes, no memory write and no cause bit.
- R5: An owned descriptor with a byte count from 1 to 2047 sends exactly that many bytes in buffer address order, which is little-endian within each word. `tx_sop` marks the first beat and `tx_eop` the last.
- R6: An owned descriptor with a byte count of 0 or of 2048 or more sends no bytes, but it is still written back and still sets its cause bit.
- R7: Write-back stores word 0 with bit 31 cleared and the other status bits kept. Words 1 to 3 are never written.
- R8: Each written-back descriptor sets cause bit 3 for queue 0 or cause bit 2 for queue 1. The cause register is at 0x450, and a write to it ANDs the cause with the written value.
- R9: The mask register is at 0x458, and `irq` is high exactly when cause AND mask is nonzero.
- R10: A write to the command register at 0x448 launches the high queue when bit 23 is set and the low queue when bit 22 is set. When both bits are set, the high ring is walked in full before the low ring.
- R11: `busy` is high from an accepted command until every launched walk ends. A command write made while `busy` is high is ignored.
- R12: A memory request holds its address, direction and write data unchanged until `mem_ready` completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory request completes |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_sop | output | 1 | First byte of a frame |
| tx_eop | output | 1 | Last byte of a frame |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A walk is pending or running |

## Verification
The hardest case to reach from the ports is a command write that lands while a walk is still running. A write made then must leave the second ring untouched. The bench provokes it by launching a low-queue walk and, on the very next register cycle, issuing a high-queue command. It then confirms that the high ring's descriptor keeps its ownership flag and that no bytes and no cause bit come from it. Ordering between queues is forced by launching both with one command while the memory stalls each request. The scoreboard only accepts the high frame before the low one. Rings that mix unowned, zero-length and oversized descriptors cover the skip and no-send paths, and a count of memory writes backs this up.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_DESC, W_DECIDE, W_FETCH, W_EMIT, W_WBACK, W_ADV
  } walk_st_t;

  localparam int OWN_BIT      = 31;
  localparam int CNT_LSB      = 16;
  localparam int CMD_HI_BIT   = 23;
  localparam int CMD_LO_BIT   = 22;
  localparam int CAUSE_Q0_BIT = 3;
  localparam int CAUSE_Q1_BIT = 2;

  localparam logic [11:0] OFS_CMD    = 12'h448;
  localparam logic [11:0] OFS_CAUSE  = 12'h450;
  localparam logic [11:0] OFS_MASK   = 12'h458;
  localparam logic [11:0] OFS_PTR_LO = 12'h4E0;
  localparam logic [11:0] OFS_PTR_HI = 12'h4E4;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int RAW = 12,
  parameter int AW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           walk_busy,
  input  logic           done_vld,
  input  logic           done_q,
  output logic [AW-1:0]  ptr_lo,
  output logic [AW-1:0]  ptr_hi,
  output logic           go,
  output logic           go_hi,
  output logic           go_lo,
  output logic           irq
);
  logic [AW-1:0] ptr_lo_n, ptr_hi_n;
  logic [31:0]   cause, cause_n, mask, mask_n;
  logic          hit_cmd;

  assign hit_cmd = reg_we && (reg_addr == RAW'(OFS_CMD));
  assign go_hi   = reg_wdata[CMD_HI_BIT];
  assign go_lo   = reg_wdata[CMD_LO_BIT];
  assign go      = hit_cmd && !walk_busy && (go_hi || go_lo);
  assign irq     = |(cause & mask);

  always_comb begin
    ptr_lo_n = ptr_lo;
    ptr_hi_n = ptr_hi;
    mask_n   = mask;
    cause_n  = cause;
    if (reg_we) begin
      if (reg_addr == RAW'(OFS_PTR_LO)) ptr_lo_n = AW'(reg_wdata);
      if (reg_addr == RAW'(OFS_PTR_HI)) ptr_hi_n = AW'(reg_wdata);
      if (reg_addr == RAW'(OFS_MASK))   mask_n   = reg_wdata;
      if (reg_addr == RAW'(OFS_CAUSE))  cause_n  = cause & reg_wdata;
    end
    if (done_vld) begin
      if (done_q) cause_n[CAUSE_Q1_BIT] = 1'b1;
      else        cause_n[CAUSE_Q0_BIT] = 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RAW'(OFS_PTR_LO): reg_rdata = 32'(ptr_lo);
      RAW'(OFS_PTR_HI): reg_rdata = 32'(ptr_hi);
      RAW'(OFS_CAUSE):  reg_rdata = cause;
      RAW'(OFS_MASK):   reg_rdata = mask;
      default:          reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_lo <= '0;
      ptr_hi <= '0;
      mask   <= '0;
      cause  <= '0;
    end else begin
      ptr_lo <= ptr_lo_n;
      ptr_hi <= ptr_hi_n;
      mask   <= mask_n;
      cause  <= cause_n;
    end
  end
endmodule

// File: rtl/txr_walk.sv
module txr_walk
  import txr_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int MAX_LEN = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_hi,
  input  logic          go_lo,
  input  logic [AW-1:0] ptr_lo,
  input  logic [AW-1:0] ptr_hi,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_sop,
  output logic          tx_eop,
  output logic          done_vld,
  output logic          done_q
);
  localparam int          WOW = CW - 2;
  localparam logic [CW:0] LIM = (CW+1)'(MAX_LEN);

  walk_st_t       st, st_n;
  logic           pend_hi, pend_hi_n, pend_lo, pend_lo_n;
  logic           q, q_n;
  logic [AW-1:0]  start_a, start_a_n, cur_a, cur_a_n;
  logic [1:0]     widx, widx_n, bidx, bidx_n;
  logic [31:0]    d_cmd, d_cmd_n, d_buf, d_buf_n, d_nxt, d_nxt_n, dword, dword_n;
  logic [CW-1:0]  d_len, d_len_n, bcnt, bcnt_n;
  logic [WOW-1:0] woff, woff_n;
  logic           xfer, last_b;

  assign mem_req   = (st == W_DESC) || (st == W_FETCH) || (st == W_WBACK);
  assign mem_we    = (st == W_WBACK);
  assign xfer      = mem_req && mem_ready;
  assign mem_wdata = d_cmd & ~(32'd1 << OWN_BIT);
  assign busy      = (st != W_IDLE) || pend_hi || pend_lo;
  assign done_vld  = (st == W_WBACK) && mem_ready;
  assign done_q    = q;
  assign tx_valid  = (st == W_EMIT);
  assign tx_data   = dword[{bidx, 3'b000} +: 8];
  assign last_b    = (bcnt == d_len - CW'(1));
  assign tx_sop    = tx_valid && (bcnt == '0);
  assign tx_eop    = tx_valid && last_b;

  always_comb begin
    case (st)
      W_FETCH: mem_addr = AW'(d_buf) + AW'({woff, 2'b00});
      W_WBACK: mem_addr = cur_a;
      default: mem_addr = cur_a + AW'({widx, 2'b00});
    endcase
  end

  always_comb begin
    st_n      = st;
    pend_hi_n = pend_hi || (go && go_hi);
    pend_lo_n = pend_lo || (go && go_lo);
    q_n       = q;
    start_a_n = start_a;
    cur_a_n   = cur_a;
    widx_n    = widx;
    bidx_n    = bidx;
    d_cmd_n   = d_cmd;
    d_len_n   = d_len;
    d_buf_n   = d_buf;
    d_nxt_n   = d_nxt;
    dword_n   = dword;
    bcnt_n    = bcnt;
    woff_n    = woff;
    case (st)
      W_IDLE: begin
        widx_n = '0;
        if (pend_hi) begin
          pend_hi_n = 1'b0;
          q_n       = 1'b1;
          start_a_n = ptr_hi;
          cur_a_n   = ptr_hi;
          st_n      = W_DESC;
        end else if (pend_lo) begin
          pend_lo_n = 1'b0;
          q_n       = 1'b0;
          start_a_n = ptr_lo;
          cur_a_n   = ptr_lo;
          st_n      = W_DESC;
        end
      end
      W_DESC: if (xfer) begin
        case (widx)
          2'd0: d_cmd_n = mem_rdata;
          2'd1: d_len_n = mem_rdata[CNT_LSB +: CW];
          2'd2: d_buf_n = mem_rdata;
          default: d_nxt_n = mem_rdata;
        endcase
        widx_n = widx + 2'd1;
        if (widx == 2'd3) st_n = W_DECIDE;
      end
      W_DECIDE: begin
        woff_n = '0;
        bidx_n = '0;
        bcnt_n = '0;
        if (!d_cmd[OWN_BIT])                            st_n = W_ADV;
        else if ((d_len != '0) && ({1'b0, d_len} < LIM)) st_n = W_FETCH;
        else                                            st_n = W_WBACK;
      end
      W_FETCH: if (xfer) begin
        dword_n = mem_rdata;
        st_n    = W_EMIT;
      end
      W_EMIT: begin
        bcnt_n = bcnt + CW'(1);
        bidx_n = bidx + 2'd1;
        if (last_b) st_n = W_WBACK;
        else if (bidx == 2'd3) begin
          woff_n = woff + WOW'(1);
          st_n   = W_FETCH;
        end
      end
      W_WBACK: if (mem_ready) st_n = W_ADV;
      W_ADV: begin
        cur_a_n = AW'(d_nxt);
        widx_n  = '0;
        st_n    = (AW'(d_nxt) == start_a) ? W_IDLE : W_DESC;
      end
      default: st_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      pend_hi <= 1'b0;
      pend_lo <= 1'b0;
      q       <= 1'b0;
      start_a <= '0;
      cur_a   <= '0;
      widx    <= '0;
      bidx    <= '0;
      d_cmd   <= '0;
      d_len   <= '0;
      d_buf   <= '0;
      d_nxt   <= '0;
      dword   <= '0;
      bcnt    <= '0;
      woff    <= '0;
    end else begin
      st      <= st_n;
      pend_hi <= pend_hi_n;
      pend_lo <= pend_lo_n;
      q       <= q_n;
      start_a <= start_a_n;
      cur_a   <= cur_a_n;
      widx    <= widx_n;
      bidx    <= bidx_n;
      d_cmd   <= d_cmd_n;
      d_len   <= d_len_n;
      d_buf   <= d_buf_n;
      d_nxt   <= d_nxt_n;
      dword   <= dword_n;
      bcnt    <= bcnt_n;
      woff    <= woff_n;
    end
  end
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
  parameter int RAW     = 12,
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int MAX_LEN = 2048
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  input  logic           mem_ready,
  output logic           tx_valid,
  output logic [7:0]     tx_data,
  output logic           tx_sop,
  output logic           tx_eop,
  output logic           irq,
  output logic           busy
);
  logic          go, go_hi, go_lo, done_vld, done_q;
  logic [AW-1:0] ptr_lo, ptr_hi;

  txr_regs #(.RAW(RAW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .walk_busy(busy),
    .done_vld(done_vld), .done_q(done_q), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
    .go(go), .go_hi(go_hi), .go_lo(go_lo), .irq(irq)
  );

  txr_walk #(.AW(AW), .CW(CW), .MAX_LEN(MAX_LEN)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .go_hi(go_hi), .go_lo(go_lo),
    .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .done_vld(done_vld), .done_q(done_q)
  );
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ready,
  input logic          tx_valid,
  input logic          tx_sop,
  input logic          tx_eop,
  input logic          irq,
  input logic          busy
);
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_wb_own_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  p_marks_in_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sop || tx_eop) |-> tx_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !tx_valid);

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(reg_we) || $past(mem_req && mem_we && mem_ready));
endmodule

bind txr_engine txr_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .tx_valid(tx_valid), .tx_sop(tx_sop),
  .tx_eop(tx_eop), .irq(irq), .busy(busy)
);

// File: tb/txr_engine_tb.sv
module txr_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_sop, tx_eop, irq, busy;
  logic [7:0]  tx_data;

  always #2.5 clk = ~clk;

  txr_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .irq(irq), .busy(busy)
  );

  int checks = 0, errors = 0, nwrites = 0, stall = 0, wcnt = 0, cyc = 0;
  logic [31:0] mem [0:4095];
  logic [9:0]  exp_q [$];

  assign mem_rdata = mem[mem_addr[13:2]];

  // memory model: ready after 'stall' extra cycles, dropped after each completion
  always @(negedge clk) begin
    if (!rst_n) begin mem_ready <= 1'b0; wcnt = 0; end
    else if (mem_ready) begin mem_ready <= 1'b0; wcnt = 0; end
    else if (mem_req) begin
      if (wcnt >= stall) mem_ready <= 1'b1;
      else wcnt++;
    end
  end

  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ready && mem_we) begin
      mem[mem_addr[13:2]] = mem_wdata;
      nwrites++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected byte", {22'd0, tx_sop, tx_eop, tx_data}, 32'd0);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({tx_sop, tx_eop, tx_data} == e, "R5 stream beat", {22'd0, tx_sop, tx_eop, tx_data}, {22'd0, e});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: busy stuck actual 0x%08h expected 0x%08h", {31'd0, busy}, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  // driver: build descriptor, fill buffer, push expected beats
  task automatic put_desc(input int a, input bit own, input int len, input int buf_a,
                          input int nxt, input int seed);
    mem[a >> 2]       = 32'h0035_0010 | (own ? 32'h8000_0000 : 32'h0);
    mem[(a >> 2) + 1] = {len[15:0], 16'hBEEF};
    mem[(a >> 2) + 2] = buf_a;
    mem[(a >> 2) + 3] = nxt;
    if (len > 0 && len < 2048) begin
      for (int i = 0; i < len; i++) begin
        int ba;
        ba = buf_a + i;
        mem[ba >> 2][8*(ba % 4) +: 8] = 8'(seed + i);
        if (own) exp_q.push_back({(i == 0), (i == len - 1), 8'(seed + i)});
      end
    end
  endtask

  task automatic chk_wb(input int a, input bit own_before, input string req);
    logic [31:0] e0;
    e0 = 32'h0035_0010 | (own_before ? 32'h8000_0000 : 32'h0);
    if (own_before) e0[31] = 1'b0;
    chk(mem[a >> 2] == e0, req, mem[a >> 2], e0);
  endtask

  initial begin
    logic [31:0] rd;
    int w0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk(!busy && !irq && !mem_req && !tx_valid, "R1 outputs idle", {busy, irq, mem_req, tx_valid}, 0);
    reg_read(12'h4E0, rd); chk(rd == 0, "R1 ptr lo", rd, 0);
    reg_read(12'h450, rd); chk(rd == 0, "R1 cause", rd, 0);
    reg_read(12'h458, rd); chk(rd == 0, "R1 mask", rd, 0);

    // R2 pointer registers
    reg_write(12'h4E0, 32'h100);
    reg_write(12'h4E4, 32'h200);
    reg_read(12'h4E0, rd); chk(rd == 32'h100, "R2 ptr lo readback", rd, 32'h100);
    reg_read(12'h4E4, rd); chk(rd == 32'h200, "R2 ptr hi readback", rd, 32'h200);

    // R3 R4 R5 R7: low ring, owned / unowned / owned
    put_desc(32'h100, 1, 5, 32'h1000, 32'h120, 8'h10);
    put_desc(32'h120, 0, 9, 32'h1100, 32'h140, 8'h40);
    put_desc(32'h140, 1, 8, 32'h1202, 32'h100, 8'h80);
    mem[32'h1200 >> 2] = '0;
    put_desc(32'h140, 1, 8, 32'h1200, 32'h100, 8'h80);
    void'(exp_q.pop_back()); // second put duplicated the expected beats; rebuild cleanly
    exp_q.delete();
    put_desc(32'h100, 1, 5, 32'h1000, 32'h120, 8'h10);
    put_desc(32'h140, 1, 8, 32'h1200, 32'h100, 8'h80);
    reg_write(12'h458, 32'h8);
    nwrites = 0;
    reg_write(12'h448, 32'h0040_0000);
    chk(busy, "R11 busy after command", {31'd0, busy}, 1);
    wait_idle();
    chk(exp_q.size() == 0, "R5 low ring frames complete", exp_q.size(), 0);
    chk(nwrites == 2, "R4 only owned descriptors written", nwrites, 2);
    chk_wb(32'h100, 1, "R7 first descriptor released");
    chk_wb(32'h120, 0, "R4 unowned descriptor untouched");
    chk_wb(32'h140, 1, "R7 last descriptor released");
    chk(mem[(32'h140 >> 2) + 1] == {16'd8, 16'hBEEF}, "R7 count word kept", mem[(32'h140 >> 2) + 1], {16'd8, 16'hBEEF});
    reg_read(12'h450, rd); chk(rd == 32'h8, "R8 queue0 sets bit3", rd, 32'h8);
    chk(irq, "R9 irq with mask bit3", {31'd0, irq}, 1);
    reg_write(12'h450, 32'hFFFF_FFF7);
    reg_read(12'h450, rd); chk(rd == 0, "R8 AND write clears", rd, 0);
    chk(!irq, "R9 irq drops", {31'd0, irq}, 0);

    // R6: high ring with oversized, zero-length and one-byte frames
    put_desc(32'h200, 1, 3000, 32'h1300, 32'h220, 8'h00);
    put_desc(32'h220, 1, 0,    32'h1300, 32'h240, 8'h00);
    put_desc(32'h240, 1, 1,    32'h1400, 32'h200, 8'hC3);
    nwrites = 0;
    reg_write(12'h448, 32'h0080_0000);
    wait_idle();
    chk(exp_q.size() == 0, "R6 only the one-byte frame sent", exp_q.size(), 0);
    chk(nwrites == 3, "R6 all owned written back", nwrites, 3);
    chk_wb(32'h200, 1, "R6 oversized released");
    chk_wb(32'h220, 1, "R6 zero length released");
    reg_read(12'h450, rd); chk(rd == 32'h4, "R8 queue1 sets bit2", rd, 32'h4);
    chk(!irq, "R9 masked cause keeps irq low", {31'd0, irq}, 0);
    reg_write(12'h458, 32'hC);
    chk(irq, "R9 mask write raises irq", {31'd0, irq}, 1);
    reg_write(12'h450, 32'h0);

    // R10: both queues in one command, memory stalls, high must come first
    stall = 2;
    put_desc(32'h400, 1, 7, 32'h1600, 32'h400, 8'h70);
    put_desc(32'h300, 1, 6, 32'h1500, 32'h300, 8'h30);
    reg_write(12'h4E0, 32'h300);
    reg_write(12'h4E4, 32'h400);
    reg_write(12'h448, 32'h00C0_0000);
    wait_idle();
    chk(exp_q.size() == 0, "R10 both frames in high-first order", exp_q.size(), 0);
    reg_read(12'h450, rd); chk(rd == 32'hC, "R10 both causes", rd, 32'hC);
    reg_write(12'h450, 32'h0);
    stall = 0;

    // R11: command during a walk is ignored
    put_desc(32'h500, 1, 4, 32'h1700, 32'h500, 8'h50);
    mem[32'h600 >> 2] = 32'h8035_0010;
    mem[(32'h600 >> 2) + 1] = {16'd4, 16'hBEEF};
    mem[(32'h600 >> 2) + 2] = 32'h1800;
    mem[(32'h600 >> 2) + 3] = 32'h600;
    reg_write(12'h4E0, 32'h500);
    reg_write(12'h4E4, 32'h600);
    reg_write(12'h448, 32'h0040_0000);
    chk(busy, "R11 busy during walk", {31'd0, busy}, 1);
    reg_write(12'h448, 32'h0080_0000);
    wait_idle();
    chk(exp_q.size() == 0, "R11 only low frame sent", exp_q.size(), 0);
    chk(mem[32'h600 >> 2] == 32'h8035_0010, "R11 high ring untouched", mem[32'h600 >> 2], 32'h8035_0010);
    reg_read(12'h450, rd); chk(rd == 32'h8, "R11 no high cause", rd, 32'h8);
    reg_write(12'h450, 32'h0);

    // R4: ring of one unowned descriptor
    put_desc(32'h700, 0, 4, 32'h1900, 32'h700, 8'h00);
    reg_write(12'h4E0, 32'h700);
    nwrites = 0;
    reg_write(12'h448, 32'h0040_0000);
    wait_idle();
    w0 = nwrites;
    chk(w0 == 0, "R4 unowned ring no writes", w0, 0);
    reg_read(12'h450, rd); chk(rd == 0, "R4 unowned ring no cause", rd, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule